// File: doc/BRIEF.md
# Lane Alignment Transmit Sequencer

This block controls the transmit side of a multi-gigabit converter lane while the link comes up. Each character clock it produces one octet and a flag that marks that octet as a control character. The octet stream goes to a downstream 8b/10b encoder. While the receiver asks for synchronization, the block sends the comma character. Once the request is withdrawn, it waits for the next local multiframe boundary. It then plays a four-multiframe alignment sequence and after that forwards the user octet stream.

The alignment sequence has a fixed frame. Each multiframe opens with a start marker and closes with an end marker. The second multiframe carries a configuration marker and fourteen link configuration octets, taken from an input bus and sent exactly as given. Every other slot carries a ramp equal to the slot's position in the multiframe. During the whole sequence the block raises a flag that tells the scrambler to pass the characters through untouched. If the receiver requests synchronization again at any point, the block drops back to the comma character on the next character clock.

Top module: `lane_align_tx`

## Requirements
- R1: While `sync_req_ni` is sampled low, the next output character is 8'hBC with `tx_is_k_o`=1 and `scr_bypass_o`=0.
- R2: After `sync_req_ni` is first sampled high, the output stays 8'hBC/control. The sequence starts only on an `lmfc_edge_i` pulse sampled in a later cycle than the release. The first sequence character appears on the output one cycle after that pulse is sampled.
- R3: The sequence lasts exactly 4*MF_LEN characters, and `scr_bypass_o` is high for exactly those characters. Further `lmfc_edge_i` pulses during the sequence or in user data have no effect.
- R4: Position 0 of each of the four multiframes carries 8'h1C as a control character. Position MF_LEN-1 carries 8'h7C as a control character.
- R5: In the second multiframe, position 1 carries 8'h9C as a control character.
- R6: In the second multiframe, positions 2 to 15 carry configuration octet j = `cfg_octets_i[8*j+7:8*j]` at position j+2, unchanged, with `tx_is_k_o`=0.
- R7: Every other sequence position p carries the data octet p mod 256, with `tx_is_k_o`=0. The ramp restarts at 0 in each multiframe.
- R8: If `sync_req_ni` is sampled low during the sequence or during user data, the next output is 8'hBC/control with `scr_bypass_o`=0. After a later release the block again waits for a fresh boundary pulse in a later cycle.
- R9: After the last end marker of the sequence, each output equals `user_data_i` as sampled one cycle earlier, with `tx_is_k_o`=0 and `scr_bypass_o`=0.
- R10: While `rst_ni` is low, the output is 8'hBC with `tx_is_k_o`=1 and `scr_bypass_o`=0, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Character clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sync_req_ni | input | 1 | Active-low synchronization request from the receiver |
| lmfc_edge_i | input | 1 | One-cycle pulse that marks a local multiframe boundary |
| cfg_octets_i | input | 112 | Fourteen link configuration octets; octet j in bits 8*j+7:8*j |
| user_data_i | input | 8 | User octet stream, forwarded after the alignment sequence |
| tx_data_o | output | 8 | Octet to the 8b/10b encoder |
| tx_is_k_o | output | 1 | High when `tx_data_o` is a control character |
| scr_bypass_o | output | 1 | High while the alignment sequence is being sent |

## Verification
The checker assumes that `lmfc_edge_i` is a single-cycle pulse and that `cfg_octets_i` stays stable for the whole sequence. It also assumes that MF_LEN is at least 17, so that the configuration slots fit between the markers. The stimulus changes the configuration bus only while the block is sending commas. It pulses the boundary input once per multiframe, and sometimes together with the release cycle, to test that a same-cycle pulse is not taken as the start. Requests that abort the sequence are placed at the first slot, in the middle of the second multiframe and inside user data.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;

    typedef enum logic [1:0] {
        PH_COMMA = 2'd0,
        PH_ARMED = 2'd1,
        PH_ALIGN = 2'd2,
        PH_USER  = 2'd3
    } phase_e;

    localparam logic [7:0] CH_COMMA  = 8'hBC;
    localparam logic [7:0] CH_START  = 8'h1C;
    localparam logic [7:0] CH_END    = 8'h7C;
    localparam logic [7:0] CH_CFGMRK = 8'h9C;

    localparam int ALIGN_MFS   = 4;
    localparam int CFG_COUNT   = 14;
    localparam int CFG_FIRST   = 2;
    localparam int CFG_MF      = 1;

    typedef struct packed {
        logic [7:0] data;
        logic       is_k;
    } char_t;

endpackage

// File: rtl/lane_align_ctrl.sv
module lane_align_ctrl
    import lane_align_pkg::*;
#(
    parameter int MF_LEN = 32,
    localparam int IDX_W = (MF_LEN > 1) ? $clog2(MF_LEN) : 1,
    localparam int MF_W  = $clog2(ALIGN_MFS)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sync_req_ni,
    input  logic             lmfc_edge_i,
    output phase_e           phase_d_o,
    output logic [MF_W-1:0]  mf_d_o,
    output logic [IDX_W-1:0] idx_d_o
);

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(MF_LEN - 1);
    localparam logic [MF_W-1:0]  MF_LAST  = MF_W'(ALIGN_MFS - 1);

    typedef struct packed {
        phase_e           phase;
        logic [MF_W-1:0]  mf;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (!sync_req_ni) begin
            seq_d.phase = PH_COMMA;
            seq_d.mf    = '0;
            seq_d.idx   = '0;
        end else begin
            unique case (seq_q.phase)
                PH_COMMA: begin
                    seq_d.phase = PH_ARMED;
                end
                PH_ARMED: begin
                    if (lmfc_edge_i) begin
                        seq_d.phase = PH_ALIGN;
                        seq_d.mf    = '0;
                        seq_d.idx   = '0;
                    end
                end
                PH_ALIGN: begin
                    if (seq_q.idx == IDX_LAST) begin
                        seq_d.idx = '0;
                        if (seq_q.mf == MF_LAST) begin
                            seq_d.phase = PH_USER;
                            seq_d.mf    = '0;
                        end else begin
                            seq_d.mf = seq_q.mf + 1'b1;
                        end
                    end else begin
                        seq_d.idx = seq_q.idx + 1'b1;
                    end
                end
                PH_USER: begin
                    seq_d.phase = PH_USER;
                end
                default: begin
                    seq_d.phase = PH_COMMA;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '{phase: PH_COMMA, mf: '0, idx: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign phase_d_o = seq_d.phase;
    assign mf_d_o    = seq_d.mf;
    assign idx_d_o   = seq_d.idx;

endmodule

// File: rtl/lane_align_charsel.sv
module lane_align_charsel
    import lane_align_pkg::*;
#(
    parameter int MF_LEN = 32,
    localparam int IDX_W = (MF_LEN > 1) ? $clog2(MF_LEN) : 1,
    localparam int MF_W  = $clog2(ALIGN_MFS)
) (
    input  logic [MF_W-1:0]        mf_i,
    input  logic [IDX_W-1:0]       idx_i,
    input  logic [8*CFG_COUNT-1:0] cfg_octets_i,
    output char_t                  char_o
);

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(MF_LEN - 1);

    logic [7:0] cfg_arr [CFG_COUNT];
    logic [7:0] ramp;
    logic       in_cfg_mf;

    for (genvar j = 0; j < CFG_COUNT; j++) begin : g_cfg_unpack
        assign cfg_arr[j] = cfg_octets_i[8*j +: 8];
    end

    assign ramp      = 8'(idx_i);
    assign in_cfg_mf = (mf_i == MF_W'(CFG_MF));

    always_comb begin
        char_o.data = ramp;
        char_o.is_k = 1'b0;
        if (idx_i == '0) begin
            char_o.data = CH_START;
            char_o.is_k = 1'b1;
        end else if (idx_i == IDX_LAST) begin
            char_o.data = CH_END;
            char_o.is_k = 1'b1;
        end else if (in_cfg_mf && idx_i == IDX_W'(1)) begin
            char_o.data = CH_CFGMRK;
            char_o.is_k = 1'b1;
        end else if (in_cfg_mf) begin
            for (int j = 0; j < CFG_COUNT; j++) begin
                if (idx_i == IDX_W'(j + CFG_FIRST)) begin
                    char_o.data = cfg_arr[j];
                end
            end
        end
    end

endmodule

// File: rtl/lane_align_tx.sv
module lane_align_tx
    import lane_align_pkg::*;
#(
    parameter int MF_LEN = 32,
    localparam int IDX_W = (MF_LEN > 1) ? $clog2(MF_LEN) : 1,
    localparam int MF_W  = $clog2(ALIGN_MFS)
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   sync_req_ni,
    input  logic                   lmfc_edge_i,
    input  logic [8*CFG_COUNT-1:0] cfg_octets_i,
    input  logic [7:0]             user_data_i,
    output logic [7:0]             tx_data_o,
    output logic                   tx_is_k_o,
    output logic                   scr_bypass_o
);

    typedef struct packed {
        char_t ch;
        logic  bypass;
    } out_t;

    phase_e           phase_d;
    logic [MF_W-1:0]  mf_d;
    logic [IDX_W-1:0] idx_d;
    char_t            align_ch;
    out_t             out_d, out_q;

    lane_align_ctrl #(.MF_LEN(MF_LEN)) ctrl_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .sync_req_ni (sync_req_ni),
        .lmfc_edge_i (lmfc_edge_i),
        .phase_d_o   (phase_d),
        .mf_d_o      (mf_d),
        .idx_d_o     (idx_d)
    );

    lane_align_charsel #(.MF_LEN(MF_LEN)) charsel_i (
        .mf_i         (mf_d),
        .idx_i        (idx_d),
        .cfg_octets_i (cfg_octets_i),
        .char_o       (align_ch)
    );

    always_comb begin
        out_d.ch.data = CH_COMMA;
        out_d.ch.is_k = 1'b1;
        out_d.bypass  = 1'b0;
        unique case (phase_d)
            PH_ALIGN: begin
                out_d.ch     = align_ch;
                out_d.bypass = 1'b1;
            end
            PH_USER: begin
                out_d.ch.data = user_data_i;
                out_d.ch.is_k = 1'b0;
            end
            default: begin
                out_d.ch.data = CH_COMMA;
                out_d.ch.is_k = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_q <= '{ch: '{data: CH_COMMA, is_k: 1'b1}, bypass: 1'b0};
        end else begin
            out_q <= out_d;
        end
    end

    assign tx_data_o    = out_q.ch.data;
    assign tx_is_k_o    = out_q.ch.is_k;
    assign scr_bypass_o = out_q.bypass;

endmodule

// File: rtl/lane_align_chk.sv
module lane_align_chk
    import lane_align_pkg::*;
#(
    parameter int MF_LEN = 32
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       sync_req_ni,
    input logic       lmfc_edge_i,
    input logic [7:0] user_data_i,
    input logic [7:0] tx_data_o,
    input logic       tx_is_k_o,
    input logic       scr_bypass_o
);

    logic [31:0] run_cnt;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            run_cnt <= '0;
        end else if (scr_bypass_o) begin
            run_cnt <= run_cnt + 1'b1;
        end else begin
            run_cnt <= '0;
        end
    end

    // R1
    a_r1_comma_on_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sync_req_ni |=> (tx_data_o == CH_COMMA && tx_is_k_o && !scr_bypass_o));

    // R2
    a_r2_start_on_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(scr_bypass_o) |-> ($past(lmfc_edge_i) && $past(sync_req_ni)));

    // R3
    a_r3_sequence_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(scr_bypass_o) && $past(sync_req_ni)) |-> (run_cnt == 32'(4 * MF_LEN)));

    // R3
    a_r3_no_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
        scr_bypass_o |-> (run_cnt < 32'(4 * MF_LEN)));

    // R4
    a_r4_opens_with_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(scr_bypass_o) |-> (tx_data_o == CH_START && tx_is_k_o));

    // R4
    a_r4_end_then_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (scr_bypass_o && tx_is_k_o && tx_data_o == CH_END)
        |=> (!scr_bypass_o || (tx_data_o == CH_START && tx_is_k_o)));

    // R8
    a_r8_abort_drops_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (scr_bypass_o && !sync_req_ni) |=> !scr_bypass_o);

    // R9
    a_r9_user_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(scr_bypass_o) && $past(sync_req_ni))
        |-> (!tx_is_k_o && tx_data_o == $past(user_data_i)));

endmodule

bind lane_align_tx lane_align_chk #(.MF_LEN(MF_LEN)) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sync_req_ni  (sync_req_ni),
    .lmfc_edge_i  (lmfc_edge_i),
    .user_data_i  (user_data_i),
    .tx_data_o    (tx_data_o),
    .tx_is_k_o    (tx_is_k_o),
    .scr_bypass_o (scr_bypass_o)
);

// File: tb/lane_align_tx_tb.sv
module lane_align_tx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int MF         = 20;
    localparam int NCFG       = 14;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sync_n = 1'b0;
    logic              lmfc = 1'b0;
    logic [8*NCFG-1:0] cfg = '0;
    logic [7:0]        udata = '0;
    logic [7:0]        tx_data;
    logic              tx_k;
    logic              byp;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_align_tx #(.MF_LEN(MF)) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .sync_req_ni  (sync_n),
        .lmfc_edge_i  (lmfc),
        .cfg_octets_i (cfg),
        .user_data_i  (udata),
        .tx_data_o    (tx_data),
        .tx_is_k_o    (tx_k),
        .scr_bypass_o (byp)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input logic [7:0] d, input logic k, input logic b, input string req);
        checks++;
        if (tx_data !== d || tx_k !== k || byp !== b) begin
            fails++;
            $display("FAIL %s act data=%02h k=%0b byp=%0b exp data=%02h k=%0b byp=%0b",
                     req, tx_data, tx_k, byp, d, k, b);
        end
    endtask

    function automatic logic [8:0] align_char(input int m, input int p, input logic [8*NCFG-1:0] c);
        if (p == 0) return {1'b1, 8'h1C};
        if (p == MF - 1) return {1'b1, 8'h7C};
        if (m == 1 && p == 1) return {1'b1, 8'h9C};
        if (m == 1 && p >= 2 && p < 2 + NCFG) return {1'b0, c[8*(p-2) +: 8]};
        return {1'b0, 8'(p % 256)};
    endfunction

    function automatic string req_of(input int m, input int p);
        if (p == 0 || p == MF - 1) return "R4";
        if (m == 1 && p == 1) return "R5";
        if (m == 1 && p >= 2 && p < 2 + NCFG) return "R6";
        return "R7";
    endfunction

    task automatic arm(input int delay);
        sync_n = 1'b0; lmfc = 1'b0;
        step(); expect_out(8'hBC, 1'b1, 1'b0, "R1");
        step(); expect_out(8'hBC, 1'b1, 1'b0, "R1");
        sync_n = 1'b1;
        step(); expect_out(8'hBC, 1'b1, 1'b0, "R2");
        for (int i = 0; i < delay; i++) begin
            step(); expect_out(8'hBC, 1'b1, 1'b0, "R2");
        end
    endtask

    task automatic play_align(input int abort_at);
        logic [8:0] e;
        lmfc = 1'b1;
        for (int n = 0; n < 4 * MF; n++) begin
            if (n == abort_at) begin
                sync_n = 1'b0; lmfc = 1'b0;
                step(); expect_out(8'hBC, 1'b1, 1'b0, "R8");
                return;
            end
            step();
            lmfc = ((n + 1) % MF == 0) || (n % 7 == 3);
            e = align_char(n / MF, n % MF, cfg);
            expect_out(e[7:0], e[8], 1'b1, req_of(n / MF, n % MF));
        end
        lmfc = 1'b0;
    endtask

    task automatic play_user(input int count, input int seed);
        for (int u = 0; u < count; u++) begin
            udata = 8'(seed + u * 37);
            lmfc  = (u % 3 == 1);
            step(); expect_out(8'(seed + u * 37), 1'b0, 1'b0, (u == 0) ? "R9" : "R3 R9");
        end
        lmfc = 1'b0;
    endtask

    task automatic load_cfg(input int t);
        for (int j = 0; j < NCFG; j++) cfg[8*j +: 8] = 8'(j * 17 + t * 29 + 1);
    endtask

    initial begin
        rst_n = 1'b0; sync_n = 1'b1; lmfc = 1'b1; udata = 8'h55;
        step(); expect_out(8'hBC, 1'b1, 1'b0, "R10");
        step(); expect_out(8'hBC, 1'b1, 1'b0, "R10");
        lmfc = 1'b0; sync_n = 1'b0;
        rst_n = 1'b1;
        step(); expect_out(8'hBC, 1'b1, 1'b0, "R10 R1");

        for (int t = 0; t < 5; t++) begin
            load_cfg(t);
            arm(t);
            play_align(-1);
            play_user(6, t * 11 + 3);
        end

        // boundary pulse in the release cycle must not start the sequence
        load_cfg(7);
        sync_n = 1'b0;
        step(); expect_out(8'hBC, 1'b1, 1'b0, "R1");
        sync_n = 1'b1; lmfc = 1'b1;
        step(); expect_out(8'hBC, 1'b1, 1'b0, "R2");
        lmfc = 1'b0;
        step(); expect_out(8'hBC, 1'b1, 1'b0, "R2");
        play_align(-1);
        play_user(3, 91);

        // abort in the second multiframe, then re-release with same-cycle pulse
        arm(1);
        play_align(MF + 5);
        sync_n = 1'b1; lmfc = 1'b1;
        step(); expect_out(8'hBC, 1'b1, 1'b0, "R8");
        lmfc = 1'b0;
        step(); expect_out(8'hBC, 1'b1, 1'b0, "R8");
        play_align(-1);
        play_user(3, 17);

        // abort in user data
        sync_n = 1'b0;
        step(); expect_out(8'hBC, 1'b1, 1'b0, "R8");
        step(); expect_out(8'hBC, 1'b1, 1'b0, "R1");

        // abort on the very first slot
        arm(2);
        play_align(0);
        arm(0);
        play_align(-1);
        play_user(2, 200);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule